// File: doc/BRIEF.md
# Security State Transition Controller

This block sits next to a simple instruction pipeline and keeps track of which security world the core is in, trusted (Secure) or untrusted (Non-secure). For each resolved branch the pipeline hands it the branch target, the kind of branch, the instruction word found at the target, the memory attribution of the target and the current link value. One cycle later the block reports the new security world and a link-register write. It may also report a redirect to a recovered return address, a push or pop on its private return stack, or a fault request with its fault class.

There are only three ways to move between worlds. A world-exchanging branch or call from the trusted side leaves it when the target's bit 0 is clear. An untrusted branch may land on the entry marker word inside a callable region. An untrusted branch may also go to the hidden-return marker, which recovers a trusted return address that the untrusted side never sees. Any other untrusted attempt to reach trusted memory raises a fault. A configuration input selects the fault class.

Top module: `sec_xfer_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the core in the trusted world (`st_secure`=1) with an empty return stack and all pulse outputs (`lr_we`, `pc_we`, `push_req`, `pop_req`, `fault_req`) at 0.
- R2: In the trusted world, an exchange branch (`ev_kind`=1) whose target has bit 0 clear moves the core to the untrusted world. With bit 0 set the core stays trusted. Neither case writes the link register.
- R3: In the trusted world, a cross call (`ev_kind`=2) with target bit 0 clear and a non-full stack pushes the return address, asserts `push_req` and `lr_we` with `lr_out`=0xFEFFFFFF, and moves the core to the untrusted world.
- R4: In the trusted world, a cross call whose target has bit 0 set keeps the core trusted, pushes nothing, and writes `ev_ret_addr` to the link register.
- R5: In the untrusted world, a branch of any kind whose target matches 0xFEFFFFFF with bit 0 ignored pops the stack, asserts `pop_req` and `pc_we`, places the saved address on `pc_out`, and returns the core to the trusted world.
- R6: The return stack holds 4 entries and is last-in first-out.
- R7: In the untrusted world, a branch to a callable region (`ev_attr`=1) whose target word is 0xE97FE97F moves the core to the trusted world and writes `ev_lr` with bit 0 cleared to the link register.
- R8: The entry marker word has no effect in any other situation: it changes neither the world nor the link register when the core is trusted, and it does neither when the target is untrusted memory (`ev_attr`=2).
- R9: In the untrusted world, a branch to trusted memory (`ev_attr`=0 or 3), or to a callable region without the entry marker word, asserts `fault_req`, keeps the core untrusted and writes no link.
- R10: When `fault_req` is raised, `fault_kind` equals the `cfg_full_fault` value sampled with the event (1 = secure-fault class, 0 = hard-fault class).
- R11: A hidden return with an empty stack, or a cross call with a full stack, raises `fault_req`, leaves the world unchanged, and leaves the stack contents unchanged.
- R12: All outputs are registered. Pulses appear exactly one cycle after an `ev_valid` cycle, and are 0 in the cycle after any cycle without an event. The world does not change without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A resolved branch event is present |
| ev_kind | input | 2 | 0 plain, 1 exchange branch, 2 cross call, 3 plain |
| ev_target | input | 32 | Branch target address |
| ev_word | input | 32 | Instruction word at the target |
| ev_attr | input | 2 | Target attribution: 0 trusted, 1 callable, 2 untrusted, 3 trusted |
| ev_ret_addr | input | 32 | Return address of a call |
| ev_lr | input | 32 | Current link-register value |
| cfg_full_fault | input | 1 | Selects the secure-fault class over the hard-fault class |
| st_secure | output | 1 | Current world, 1 = trusted |
| lr_we | output | 1 | Link-register write pulse |
| lr_out | output | 32 | New link-register value |
| pc_we | output | 1 | Redirect pulse for a hidden return |
| pc_out | output | 32 | Recovered return address |
| push_req | output | 1 | Return stack push pulse |
| pop_req | output | 1 | Return stack pop pulse |
| fault_req | output | 1 | Fault request pulse |
| fault_kind | output | 1 | Fault class that goes with `fault_req` |

## Verification
A corrupted stack pointer shows up at the ports on the next hidden return. The return reports the wrong recovered address on `pc_out`, or it raises a fault on a stack that should not be empty or full, and this happens one cycle after that event. A wrong world bit shows up on `st_secure` one cycle after the event that set it. Every later branch is then decided by the wrong rules, so gateway and fault outcomes diverge right away. The directed bench walks the stack to full and back to empty, so that pointer and ordering errors surface as address mismatches within four returns.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_XCHG  = 2'd1,
    K_XCALL = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    A_TRUST  = 2'd0,
    A_CALL   = 2'd1,
    A_UNTR   = 2'd2,
    A_TRUST2 = 2'd3
  } attr_e;

  localparam logic [ADDR_W-1:0] RET_MAGIC  = 32'hFEFF_FFFF;
  localparam logic [31:0]       GATE_WORD  = 32'hE97F_E97F;

  typedef struct packed {
    logic              sec;
    logic [ADDR_W-1:0] addr;
  } stk_ent_t;

  typedef struct packed {
    logic              nxt_sec;
    logic              lr_we;
    logic [ADDR_W-1:0] lr_val;
    logic              pc_we;
    logic [ADDR_W-1:0] pc_val;
    logic              push;
    logic              pop;
    logic              fault;
  } verdict_t;
endpackage

// File: rtl/sx_ret_stack.sv
module sx_ret_stack
  import sx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  logic     pop,
  input  stk_ent_t din,
  output logic     full,
  output logic     empty,
  output stk_ent_t top
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = $bits(stk_ent_t);

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] rd_idx;

  assign wr_idx = IW'(cnt);
  assign rd_idx = IW'(cnt - CW'(1));
  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign top    = stk_ent_t'(mem[rd_idx]);

  // storage without reset so it maps onto a RAM
  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (push && !pop && !full)  cnt <= cnt + CW'(1);
    else if (pop && !push && !empty) cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/sx_decide.sv
module sx_decide
  import sx_pkg::*;
(
  input  logic              cur_sec,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] target,
  input  logic [31:0]       word,
  input  logic [1:0]        attr,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] lr_in,
  input  logic              stk_full,
  input  logic              stk_empty,
  input  stk_ent_t          stk_top,
  output verdict_t          v
);
  logic magic_hit;
  logic gate_hit;

  assign magic_hit = (target[ADDR_W-1:1] == RET_MAGIC[ADDR_W-1:1]);
  assign gate_hit  = (attr == A_CALL) && (word == GATE_WORD);

  always_comb begin
    v         = '0;
    v.nxt_sec = cur_sec;
    if (cur_sec) begin
      unique case (kind_e'(kind))
        K_XCHG: begin
          if (!target[0]) v.nxt_sec = 1'b0;
        end
        K_XCALL: begin
          if (!target[0]) begin
            if (stk_full) begin
              v.fault = 1'b1;
            end else begin
              v.push    = 1'b1;
              v.lr_we   = 1'b1;
              v.lr_val  = RET_MAGIC;
              v.nxt_sec = 1'b0;
            end
          end else begin
            v.lr_we  = 1'b1;
            v.lr_val = ret_addr;
          end
        end
        default: ;
      endcase
    end else begin
      if (magic_hit) begin
        if (stk_empty) begin
          v.fault = 1'b1;
        end else begin
          v.pop     = 1'b1;
          v.pc_we   = 1'b1;
          v.pc_val  = stk_top.addr;
          v.nxt_sec = stk_top.sec;
        end
      end else if (gate_hit) begin
        v.nxt_sec = 1'b1;
        v.lr_we   = 1'b1;
        v.lr_val  = {lr_in[ADDR_W-1:1], 1'b0};
      end else if (attr != A_UNTR) begin
        v.fault = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sec_xfer_ctrl.sv
module sec_xfer_ctrl
  import sx_pkg::*;
#(
  parameter int STK_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_valid,
  input  logic [1:0]  ev_kind,
  input  logic [31:0] ev_target,
  input  logic [31:0] ev_word,
  input  logic [1:0]  ev_attr,
  input  logic [31:0] ev_ret_addr,
  input  logic [31:0] ev_lr,
  input  logic        cfg_full_fault,
  output logic        st_secure,
  output logic        lr_we,
  output logic [31:0] lr_out,
  output logic        pc_we,
  output logic [31:0] pc_out,
  output logic        push_req,
  output logic        pop_req,
  output logic        fault_req,
  output logic        fault_kind
);
  verdict_t v;
  stk_ent_t top;
  stk_ent_t din;
  logic     full, empty;

  assign din = '{sec: 1'b1, addr: ev_ret_addr};

  sx_ret_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk   (clk),
    .rst   (rst),
    .push  (ev_valid && v.push),
    .pop   (ev_valid && v.pop),
    .din   (din),
    .full  (full),
    .empty (empty),
    .top   (top)
  );

  sx_decide u_dec (
    .cur_sec   (st_secure),
    .kind      (ev_kind),
    .target    (ev_target),
    .word      (ev_word),
    .attr      (ev_attr),
    .ret_addr  (ev_ret_addr),
    .lr_in     (ev_lr),
    .stk_full  (full),
    .stk_empty (empty),
    .stk_top   (top),
    .v         (v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_secure  <= 1'b1;
      lr_we      <= 1'b0;
      lr_out     <= '0;
      pc_we      <= 1'b0;
      pc_out     <= '0;
      push_req   <= 1'b0;
      pop_req    <= 1'b0;
      fault_req  <= 1'b0;
      fault_kind <= 1'b0;
    end else if (ev_valid) begin
      st_secure  <= v.nxt_sec;
      lr_we      <= v.lr_we;
      pc_we      <= v.pc_we;
      push_req   <= v.push;
      pop_req    <= v.pop;
      fault_req  <= v.fault;
      fault_kind <= v.fault && cfg_full_fault;
      if (v.lr_we) lr_out <= v.lr_val;
      if (v.pc_we) pc_out <= v.pc_val;
    end else begin
      lr_we      <= 1'b0;
      pc_we      <= 1'b0;
      push_req   <= 1'b0;
      pop_req    <= 1'b0;
      fault_req  <= 1'b0;
      fault_kind <= 1'b0;
    end
  end
endmodule

// File: rtl/sx_chk.sv
module sx_chk (
  input logic        clk,
  input logic        rst,
  input logic        ev_valid,
  input logic [1:0]  ev_kind,
  input logic [31:0] ev_target,
  input logic [31:0] ev_word,
  input logic [1:0]  ev_attr,
  input logic        cfg_full_fault,
  input logic        st_secure,
  input logic        lr_we,
  input logic [31:0] lr_out,
  input logic        push_req,
  input logic        pop_req,
  input logic        pc_we,
  input logic        fault_req,
  input logic        fault_kind
);
  a_r2_exchange_leaves: assert property (@(posedge clk) disable iff (rst)
    ev_valid && st_secure && ev_kind == 2'd1 && !ev_target[0] |=> !st_secure && !lr_we);

  a_r3_push_sets_magic: assert property (@(posedge clk) disable iff (rst)
    push_req |-> lr_we && lr_out == 32'hFEFF_FFFF && !st_secure);

  a_r5_pop_redirects: assert property (@(posedge clk) disable iff (rst)
    pop_req |-> pc_we && st_secure);

  a_r7_gate_entry: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !st_secure && ev_attr == 2'd1 && ev_word == 32'hE97F_E97F
    && ev_target[31:1] != 31'h7F7F_FFFF |=> st_secure && lr_we && !lr_out[0]);

  a_r9_fault_exclusive: assert property (@(posedge clk) disable iff (rst)
    fault_req |-> !push_req && !pop_req && !lr_we && !pc_we);

  a_r10_fault_class: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> fault_kind == (fault_req && $past(cfg_full_fault)));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !ev_valid |=> !lr_we && !pc_we && !push_req && !pop_req && !fault_req && $stable(st_secure));
endmodule

bind sec_xfer_ctrl sx_chk u_sx_chk (
  .clk            (clk),
  .rst            (rst),
  .ev_valid       (ev_valid),
  .ev_kind        (ev_kind),
  .ev_target      (ev_target),
  .ev_word        (ev_word),
  .ev_attr        (ev_attr),
  .cfg_full_fault (cfg_full_fault),
  .st_secure      (st_secure),
  .lr_we          (lr_we),
  .lr_out         (lr_out),
  .push_req       (push_req),
  .pop_req        (pop_req),
  .pc_we          (pc_we),
  .fault_req      (fault_req),
  .fault_kind     (fault_kind)
);

// File: tb/sec_xfer_ctrl_tb.sv
module sec_xfer_ctrl_tb_top;
  localparam logic [31:0] MAGIC = 32'hFEFF_FFFF;
  localparam logic [31:0] GATE  = 32'hE97F_E97F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_valid = 1'b0;
  logic [1:0]  ev_kind = '0;
  logic [31:0] ev_target = '0, ev_word = '0, ev_ret_addr = '0, ev_lr = '0;
  logic [1:0]  ev_attr = '0;
  logic cfg_full_fault = 1'b0;
  logic st_secure, lr_we, pc_we, push_req, pop_req, fault_req, fault_kind;
  logic [31:0] lr_out, pc_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_xfer_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one event, outputs checked a cycle later, idle quiet checked after that
  task automatic ev(input logic [1:0] k, input logic [31:0] t, input logic [31:0] w,
                    input logic [1:0] a, input logic [31:0] ra, input logic [31:0] lr,
                    input logic cfg);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_target = t; ev_word = w; ev_attr = a;
    ev_ret_addr = ra; ev_lr = lr; cfg_full_fault = cfg;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle_check();
    logic s;
    s = st_secure;
    @(negedge clk);
    chk(!(lr_we | pc_we | push_req | pop_req | fault_req), "R12 idle pulses",
        {27'd0, lr_we, pc_we, push_req, pop_req, fault_req}, 32'd0);
    chk(st_secure == s, "R12 idle world", {31'd0, st_secure}, {31'd0, s});
  endtask

  task automatic t_reset();
    chk(st_secure == 1'b1, "R1 reset world", {31'd0, st_secure}, 32'd1);
    chk(!(lr_we | pc_we | push_req | pop_req | fault_req), "R1 reset pulses",
        {27'd0, lr_we, pc_we, push_req, pop_req, fault_req}, 32'd0);
  endtask

  task automatic t_exchange();
    ev(2'd1, 32'h0000_2001, 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
    chk(st_secure == 1'b1 && !lr_we, "R2 bit0 set stays", {31'd0, st_secure}, 32'd1);
    ev(2'd1, 32'h0000_2000, 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
    chk(st_secure == 1'b0 && !lr_we, "R2 bit0 clear leaves", {31'd0, st_secure}, 32'd0);
    idle_check();
  endtask

  task automatic t_untrusted_side();
    // gate word on untrusted memory: no effect
    ev(2'd0, 32'h0000_3000, GATE, 2'd2, 32'd0, 32'h0000_3335, 1'b0);
    chk(st_secure == 1'b0 && !lr_we && !fault_req, "R8 gate word in untrusted mem",
        {31'd0, st_secure}, 32'd0);
    // hidden return with empty stack
    ev(2'd0, MAGIC, 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
    chk(fault_req && !pop_req && !st_secure, "R11 empty pop faults", {31'd0, fault_req}, 32'd1);
    chk(fault_kind == 1'b0, "R10 hard class", {31'd0, fault_kind}, 32'd0);
    // trusted target
    ev(2'd0, 32'h1000_0000, GATE, 2'd0, 32'd0, 32'd0, 1'b1);
    chk(fault_req && !st_secure && !lr_we, "R9 trusted target faults", {31'd0, fault_req}, 32'd1);
    chk(fault_kind == 1'b1, "R10 secure class", {31'd0, fault_kind}, 32'd1);
    // callable region without marker
    ev(2'd2, 32'h1000_0100, 32'h1234_5678, 2'd1, 32'd0, 32'd0, 1'b0);
    chk(fault_req && !st_secure, "R9 callable no marker faults", {31'd0, fault_req}, 32'd1);
    // legal entry
    ev(2'd0, 32'h1000_0200, GATE, 2'd1, 32'd0, 32'h0000_4441, 1'b0);
    chk(st_secure && lr_we && lr_out == 32'h0000_4440, "R7 gate entry", lr_out, 32'h0000_4440);
    idle_check();
  endtask

  task automatic t_trusted_misc();
    ev(2'd0, 32'h1000_0200, GATE, 2'd1, 32'd0, 32'h0000_5551, 1'b0);
    chk(st_secure && !lr_we, "R8 gate word while trusted", {31'd0, lr_we}, 32'd0);
    ev(2'd2, 32'h1000_0401, 32'd0, 2'd2, 32'h0000_6002, 32'd0, 1'b0);
    chk(st_secure && !push_req && lr_we && lr_out == 32'h0000_6002, "R4 call bit0 set",
        lr_out, 32'h0000_6002);
  endtask

  task automatic t_stack();
    for (int i = 0; i < 4; i++) begin
      ev(2'd2, 32'h0000_7000, 32'd0, 2'd2, 32'h0000_8000 + 32'(i * 16), 32'd0, 1'b0);
      chk(push_req && lr_we && lr_out == MAGIC && !st_secure, "R3 cross call push",
          lr_out, MAGIC);
      ev(2'd0, 32'h1000_0200, GATE, 2'd1, 32'd0, 32'd0, 1'b0);
    end
    ev(2'd2, 32'h0000_7000, 32'd0, 2'd2, 32'h0000_9999, 32'd0, 1'b1);
    chk(fault_req && fault_kind && !push_req && st_secure, "R11 full push faults",
        {31'd0, fault_req}, 32'd1);
    for (int i = 3; i >= 0; i--) begin
      ev(2'd1, 32'h0000_2000, 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
      ev(2'(i % 3), (i % 2 == 0) ? MAGIC : (MAGIC & ~32'd1), 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
      chk(pop_req && pc_we && st_secure, "R5 hidden return", {31'd0, st_secure}, 32'd1);
      chk(pc_out == 32'h0000_8000 + 32'(i * 16), "R6 LIFO order", pc_out,
          32'h0000_8000 + 32'(i * 16));
    end
    ev(2'd1, 32'h0000_2000, 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
    ev(2'd0, MAGIC, 32'd0, 2'd2, 32'd0, 32'd0, 1'b0);
    chk(fault_req && !pop_req && !st_secure, "R11 drained stack faults", {31'd0, fault_req}, 32'd1);
    idle_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_exchange();
    t_untrusted_side();
    t_trusted_misc();
    t_stack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule